// File: doc/BRIEF.md
# Software Reset and Event Interrupt Register Block

This block sits beside a peripheral core and gives software two facilities through one word-wide register port. The first is a reset trigger: a write of a fixed key word to the reset register produces a reset pulse of fixed length on a dedicated output, which is wired to the peripheral core. The second is interrupt handling. A bank of event inputs coming from the core is edge-detected into sticky status bits. Those bits are masked by a per-event enable register and gated by a single global enable bit, and the result drives one interrupt line.

Status bits are cleared by toggling rather than by a plain clear. Writing a one to a status bit inverts it. A handler can therefore read the status word and write the same word back, and every bit that was set is cleared. Hardware takes priority: if an event edge and a software toggle hit the same bit in the same cycle, the bit ends up set, so no event is lost. Reads are combinational from the read address. Unmapped offsets and the reset register read as zero.

Top module: `evt_irq_regs`

## Requirements
- R1: A write of 0x0000000A to offset 0x0 drives `core_rst_o` high from the cycle after the write. Offset 0x0 always reads 0.
- R2: After a key write, `core_rst_o` stays high for exactly 16 consecutive cycles and then returns low.
- R3: A write of any value other than 0x0000000A to offset 0x0 leaves `core_rst_o` low.
- R4: A status bit (offset 0x1, bit i for event i) is set in the cycle after `evt_i[i]` is first sampled high following a low sample. Holding the event high does not set the bit again once it has been cleared.
- R5: A write to offset 0x1 inverts every status bit written as one and leaves the bits written as zero unchanged. Writing back the value just read yields zero.
- R6: When an event edge and a toggle write reach the same status bit in the same cycle, the bit is one afterwards.
- R7: The enable register (offset 0x2) stores bits [NUM_EVT-1:0] of the write data, so a write of 0xFF enables all eight events. Its upper bits read as 0.
- R8: The global enable (offset 0x3) stores only bit 31 of the write data, and its other bits read as 0. While it is 0, `irq_o` is 0.
- R9: `irq_o` is high exactly when the global enable is set and at least one status bit is set whose enable bit is also set.
- R10: After `rst_n` is released, all registers read as zero and both `irq_o` and `core_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word offset of the combinational read |
| rd_data | output | DATA_W | Read data |
| evt_i | input | NUM_EVT | Event inputs from the peripheral core |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Reset pulse to the peripheral core |

## Verification
The bench builds the block with its defaults: 32-bit data, eight events, a 16-cycle pulse and the key 0x0000000A. With eight events, a write of all ones to the enable register shows that bits above bit 7 are discarded. The 32-bit word places the global-enable bit at bit 31, so writes that set every bit except bit 31 can be tested against it. The 16-cycle length is short enough to count the whole reset pulse cycle by cycle. It also leaves room to test a non-key write and the event-edge versus toggle collision on a set bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // Word offsets of the mapped registers
   localparam int unsigned OFS_SRST = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_EN   = 2;
   localparam int unsigned OFS_GIE  = 3;

   localparam logic [31:0] DEF_RST_KEY = 32'h0000_000A;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SRST,
      SEL_STAT,
      SEL_EN,
      SEL_GIE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input int unsigned ofs);
      reg_sel_e s;
      case (ofs)
         OFS_SRST: s = SEL_SRST;
         OFS_STAT: s = SEL_STAT;
         OFS_EN:   s = SEL_EN;
         OFS_GIE:  s = SEL_GIE;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/evt_srst_gen.sv
module evt_srst_gen #(
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          RST_CYCLES = 16,
   parameter logic [DATA_W-1:0]    RST_KEY    = DATA_W'(32'hA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   output logic              core_rst_o
);

   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("evt_srst_gen: RST_CYCLES must be at least 1");
   end

   logic             key_hit;
   logic [CNT_W-1:0] cnt_q;

   assign key_hit = wr_hit && (wr_data == RST_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (key_hit) begin
         cnt_q <= CNT_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign core_rst_o = (cnt_q != '0);

   // Independent observer: cycles since the last key write
   logic [CNT_W-1:0] since_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (key_hit) begin
         since_q <= '0;
         seen_q  <= 1'b1;
      end else if (since_q != CNT_LOAD) begin
         since_q <= since_q + 1'b1;
      end
   end

   AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n)
      key_hit |=> core_rst_o); // R1

   AST_RST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o == (seen_q && (since_q != CNT_LOAD))); // R2

   AST_NO_KEY_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !key_hit && !core_rst_o) |=> !core_rst_o); // R3

endmodule

// File: rtl/evt_stat_bank.sv
module evt_stat_bank #(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [NUM_EVT-1:0] tog_i,
   output logic [NUM_EVT-1:0] stat_o
);

   if (NUM_EVT < 1) begin : g_bad_evt
      $error("evt_stat_bank: NUM_EVT must be at least 1");
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic evt_q;
      logic sticky_q;
      logic rise;

      assign rise = evt_i[i] && !evt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            evt_q    <= 1'b0;
            sticky_q <= 1'b0;
         end else begin
            evt_q    <= evt_i[i];
            sticky_q <= (sticky_q ^ tog_i[i]) | rise;
         end
      end

      assign stat_o[i] = sticky_q;

      AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_i[i]) |=> stat_o[i]); // R4

      AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
         (tog_i[i] && !(evt_i[i] && !evt_q)) |=> (stat_o[i] != $past(stat_o[i]))); // R5

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (tog_i[i] && evt_i[i] && !evt_q) |=> stat_o[i]); // R6
   end

endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_EVT = 8,
   parameter int unsigned GIE_BIT = DATA_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_hit,
   input  logic               wr_gie_hit,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_EVT-1:0] stat_i,
   output logic [NUM_EVT-1:0] en_o,
   output logic               gie_o,
   output logic               irq_o
);

   if (GIE_BIT >= DATA_W) begin : g_bad_gie
      $error("evt_irq_gate: GIE_BIT outside the data word");
   end

   logic [NUM_EVT-1:0] en_q;
   logic               gie_q;
   logic [NUM_EVT-1:0] pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         gie_q <= 1'b0;
      end else begin
         if (wr_en_hit)  en_q  <= wr_data[NUM_EVT-1:0];
         if (wr_gie_hit) gie_q <= wr_data[GIE_BIT];
      end
   end

   assign pending = stat_i & en_q;
   assign irq_o   = gie_q && (pending != '0);
   assign en_o    = en_q;
   assign gie_o   = gie_q;

   AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_hit |=> (en_o == $past(wr_data[NUM_EVT-1:0]))); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_o |-> !irq_o); // R8

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_i & en_o) == '0) |-> !irq_o); // R9

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
   import evt_irq_pkg::*;
#(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       ADDR_W     = 4,
   parameter int unsigned       NUM_EVT    = 8,
   parameter int unsigned       RST_CYCLES = 16,
   parameter logic [DATA_W-1:0] RST_KEY    = DATA_W'(DEF_RST_KEY)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o,
   output logic               core_rst_o
);

   localparam int unsigned GIE_BIT = DATA_W - 1;

   if (NUM_EVT > DATA_W - 1) begin : g_bad_width
      $error("evt_irq_regs: NUM_EVT must leave the top data bit free");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("evt_irq_regs: ADDR_W must cover four registers");
   end

   reg_sel_e           wr_sel;
   reg_sel_e           rd_sel;
   logic [NUM_EVT-1:0] tog;
   logic [NUM_EVT-1:0] stat;
   logic [NUM_EVT-1:0] en;
   logic               gie;

   assign wr_sel = wr_en ? decode_ofs(int'(wr_addr)) : SEL_NONE;
   assign rd_sel = decode_ofs(int'(rd_addr));
   assign tog    = (wr_sel == SEL_STAT) ? wr_data[NUM_EVT-1:0] : '0;

   evt_srst_gen #(
      .DATA_W     (DATA_W),
      .RST_CYCLES (RST_CYCLES),
      .RST_KEY    (RST_KEY)
   ) i_srst (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_sel == SEL_SRST),
      .wr_data    (wr_data),
      .core_rst_o (core_rst_o)
   );

   evt_stat_bank #(
      .NUM_EVT (NUM_EVT)
   ) i_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .tog_i  (tog),
      .stat_o (stat)
   );

   evt_irq_gate #(
      .DATA_W  (DATA_W),
      .NUM_EVT (NUM_EVT),
      .GIE_BIT (GIE_BIT)
   ) i_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_hit  (wr_sel == SEL_EN),
      .wr_gie_hit (wr_sel == SEL_GIE),
      .wr_data    (wr_data),
      .stat_i     (stat),
      .en_o       (en),
      .gie_o      (gie),
      .irq_o      (irq_o)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_STAT: rd_data[NUM_EVT-1:0] = stat;
         SEL_EN:   rd_data[NUM_EVT-1:0] = en;
         SEL_GIE:  rd_data[GIE_BIT]     = gie;
         default:  rd_data = '0;
      endcase
   end

   AST_SRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_SRST) |-> (rd_data == '0)); // R1

   AST_GIE_ONLY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_GIE) |-> (rd_data[GIE_BIT-1:0] == '0)); // R8

endmodule

// File: tb/test_evt_irq_regs.sv
`timescale 1ns/1ps
module test_evt_irq_regs;

   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int unsigned NE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [NE-1:0] evt_i = '0;
   logic          irq_o;
   logic          core_rst_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   evt_irq_regs i_evt_irq_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .evt_i      (evt_i),
      .irq_o      (irq_o),
      .core_rst_o (core_rst_o)
   );

   // kind: 0 write, 1 read and check, 2 event pulse
   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [31:0] expd;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 4'h1, 32'h0,        32'h0,        1'b0, 4'd10}, // R10 status zero
      '{2'd1, 4'h2, 32'h0,        32'h0,        1'b0, 4'd10}, // R10 enable zero
      '{2'd1, 4'h3, 32'h0,        32'h0,        1'b0, 4'd10}, // R10 global zero
      '{2'd0, 4'h2, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd7},
      '{2'd1, 4'h2, 32'h0,        32'h000000FF, 1'b0, 4'd7},  // R7 upper bits dropped
      '{2'd2, 4'h0, 32'h05,       32'h0,        1'b0, 4'd4},
      '{2'd1, 4'h1, 32'h0,        32'h00000005, 1'b0, 4'd4},  // R4 edges set, R8 gated
      '{2'd0, 4'h3, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd8},
      '{2'd1, 4'h3, 32'h0,        32'h80000000, 1'b1, 4'd8},  // R8 only bit 31
      '{2'd0, 4'h2, 32'h0000000A, 32'h0,        1'b0, 4'd9},
      '{2'd1, 4'h1, 32'h0,        32'h00000005, 1'b0, 4'd9},  // R9 masked off
      '{2'd0, 4'h2, 32'h00000004, 32'h0,        1'b0, 4'd9},
      '{2'd1, 4'h2, 32'h0,        32'h00000004, 1'b1, 4'd9},  // R9 one unmasked
      '{2'd0, 4'h1, 32'h00000005, 32'h0,        1'b0, 4'd5},
      '{2'd1, 4'h1, 32'h0,        32'h00000000, 1'b0, 4'd5},  // R5 write back clears
      '{2'd0, 4'h1, 32'h00000030, 32'h0,        1'b0, 4'd5},
      '{2'd1, 4'h1, 32'h0,        32'h00000030, 1'b0, 4'd5},  // R5 toggle from zero
      '{2'd0, 4'h1, 32'h00000010, 32'h0,        1'b0, 4'd5},
      '{2'd1, 4'h1, 32'h0,        32'h00000020, 1'b0, 4'd5},  // R5 zeros untouched
      '{2'd0, 4'h2, 32'h000000FF, 32'h0,        1'b0, 4'd9},
      '{2'd1, 4'h1, 32'h0,        32'h00000020, 1'b1, 4'd9},  // R9
      '{2'd0, 4'h3, 32'h7FFFFFFF, 32'h0,        1'b0, 4'd8},
      '{2'd1, 4'h3, 32'h0,        32'h00000000, 1'b0, 4'd8},  // R8 cleared by bit 31
      '{2'd0, 4'h1, 32'h00000020, 32'h0,        1'b0, 4'd5},
      '{2'd1, 4'h1, 32'h0,        32'h00000000, 1'b0, 4'd5},  // R5
      '{2'd1, 4'h0, 32'h0,        32'h00000000, 1'b0, 4'd1}   // R1 reset reg reads 0
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      evt_i = m;
      @(negedge clk);
      evt_i = '0;
   endtask

   function automatic logic [31:0] rd(input logic [3:0] a);
      rd_addr = a;
      return rd_data;
   endfunction

   task automatic read_at(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #0.1;
      d = rd_data;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int          run;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      check(core_rst_o == 1'b0, "R10", {31'd0, core_rst_o}, 32'd0);
      check(irq_o == 1'b0, "R10", {31'd0, irq_o}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         case (VEC[k].kind)
            2'd0: wr(VEC[k].addr, VEC[k].data);
            2'd2: pulse(VEC[k].data[7:0]);
            default: begin
               read_at(VEC[k].addr, d);
               check(d == VEC[k].expd, $sformatf("R%0d vec %0d data", VEC[k].req, k),
                     d, VEC[k].expd);
               check(irq_o == VEC[k].exp_irq, $sformatf("R%0d vec %0d irq", VEC[k].req, k),
                     {31'd0, irq_o}, {31'd0, VEC[k].exp_irq});
            end
         endcase
      end

      // R3: a wrong key produces no reset pulse
      wr(4'h0, 32'h0000000B);
      run = 0;
      for (int c = 0; c < 20; c++) begin
         if (core_rst_o) run++;
         @(negedge clk);
      end
      check(run == 0, "R3", run, 0);

      // R1 and R2: key write, pulse of exactly 16 cycles
      wr(4'h0, 32'h0000000A);
      check(core_rst_o == 1'b1, "R1", {31'd0, core_rst_o}, 32'd1);
      run = 0;
      while (core_rst_o && run < 40) begin
         run++;
         @(negedge clk);
      end
      check(run == 16, "R2", run, 16);
      repeat (5) @(negedge clk);
      check(core_rst_o == 1'b0, "R2", {31'd0, core_rst_o}, 32'd0);

      // R6: set bit 1, then edge and toggle collide on it
      pulse(8'h02);
      read_at(4'h1, d);
      check(d == 32'h2, "R4", d, 32'h2);
      @(negedge clk);
      evt_i = 8'h02;
      wr_en = 1'b1; wr_addr = 4'h1; wr_data = 32'h2;
      @(negedge clk);
      wr_en = 1'b0;
      read_at(4'h1, d);
      check(d == 32'h2, "R6", d, 32'h2);
      // R4: held level does not set again after a clear
      wr(4'h1, 32'h2);
      repeat (3) @(negedge clk);
      read_at(4'h1, d);
      check(d == 32'h0, "R4", d, 32'h0);
      evt_i = '0;
      @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule